// File: doc/BRIEF.md
# Descriptor Image Header Checker

This block watches a byte stream that carries a device descriptor image, starting from the first header byte, and decides whether the header can be trusted. While the bytes arrive it runs two independent checksums. An 8-bit CRC covers the unique identifier. A CRC32C covers the payload region. It compares each result with the expected value stored earlier in the same header. It also picks up the payload length from the header while the stream is still running, so it knows on its own which byte is the last one of the image.

A controller pulses `start`, then presents bytes on the valid/ready input. Once the last byte of the image has been taken, `done` rises and holds. It then shows the pass/fail flags, the 64-bit identifier, the image size and a warning for an unexpected revision. Any later bytes are consumed and discarded until the next `start`.

Top module: `hdr_integrity_chk`

## Requirements
- R1: `in_ready` is always 1. Bytes offered before the first `start` are consumed with no effect. A `start` pulse clears `done`, every flag, `uid` and `image_size` to 0 on the following cycle, and the next accepted byte is header byte 0.
- R2: `id_ok` is 1 only when byte 0 equals the CRC8 of bytes 1 to 8. This CRC uses polynomial 0x07 and initial value 0xFF, processes each byte MSB first, and has no final inversion.
- R3: `uid` is bytes 1 to 8 taken little-endian, with byte 1 in bits 7:0. It is nonzero only while `id_ok` is 1; otherwise it reads 0.
- R4: `data_ok` is 1 only when the CRC32C of bytes 13 up to size-1 equals the little-endian 32-bit value in bytes 9 to 12. This CRC is reflected, uses polynomial 0x82F63B78, starts from all ones, and has its result inverted.
- R5: `image_size` equals 13 plus the low 10 bits of the little-endian 16-bit value in bytes 14 and 15. The upper 6 bits of byte 15 are ignored. The value is shown from the cycle after byte 15 is accepted.
- R6: If the image size is below 22, the image is rejected. `done` rises the cycle after byte 15 with `size_err`=1, `data_ok`=0 and `pass`=0.
- R7: `rev_warn` is 1 at completion when byte 13 is greater than 1. It has no effect on `pass`.
- R8: `pass` equals `id_ok` AND `data_ok` AND NOT `size_err`.
- R9: For a valid size, `done` rises exactly one cycle after byte size-1 is accepted, and not before. Idle cycles with `in_valid` low stall the count.
- R10: After `done`, further bytes are consumed and leave all outputs unchanged until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new image; clears results |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_ready | output | 1 | Byte can be taken (always 1) |
| in_data | input | 8 | Image byte |
| done | output | 1 | Image complete; results valid |
| pass | output | 1 | Both checksums match and size is legal |
| id_ok | output | 1 | Identifier CRC8 matches |
| data_ok | output | 1 | Payload CRC32C matches |
| size_err | output | 1 | Image size below header size |
| rev_warn | output | 1 | Revision byte greater than 1 |
| uid | output | 64 | Identifier, zero unless `id_ok` |
| image_size | output | 11 | Header length field plus 13 |

## Verification
Every result is registered once. All flags, `uid` and `done` appear one cycle after the final byte is accepted: byte size-1, or byte 15 for a short image. `image_size` appears one cycle after byte 15. The bench drives each byte at a falling edge and samples a few nanoseconds after the rising edge that accepts it. Its reference model knows which byte is final, and it compares `done` against that model at every falling edge, so an early or late completion shows up on the exact cycle. Flag values are compared after completion, `image_size` right after byte 15, and the stability of results after `done` is checked after trailing bytes have been pushed in.

// File: rtl/hdr_chk_pkg.sv
package hdr_chk_pkg;
  localparam int SIZE_W     = 11;
  localparam int LEN_BITS   = 10;
  localparam int ID_BYTES   = 8;
  localparam int DCRC_BYTES = 4;
  localparam int IDX_CRC8   = 0;
  localparam int ID_FIRST   = 1;
  localparam int DCRC_FIRST = ID_FIRST + ID_BYTES;
  localparam int PAY_START  = DCRC_FIRST + DCRC_BYTES;
  localparam int REV_IDX    = PAY_START;
  localparam int LEN_LO_IDX = PAY_START + 1;
  localparam int LEN_HI_IDX = PAY_START + 2;
  localparam int HDR_BYTES  = 22;
  localparam logic [7:0]  CRC8_POLY  = 8'h07;
  localparam logic [7:0]  CRC8_INIT  = 8'hFF;
  localparam logic [31:0] CRC32_POLY = 32'h82F63B78;
  localparam logic [31:0] CRC32_INIT = 32'hFFFFFFFF;

  // One byte of the MSB-first 8-bit CRC.
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int b = 0; b < 8; b++) begin
      r = r[7] ? ((r << 1) ^ CRC8_POLY) : (r << 1);
    end
    return r;
  endfunction

  // One byte of the reflected CRC32C.
  function automatic logic [31:0] crc32c_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int b = 0; b < 8; b++) begin
      r = r[0] ? ((r >> 1) ^ CRC32_POLY) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/hdr_byte_seq.sv
module hdr_byte_seq
  import hdr_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  input  logic              finish,
  output logic              take,
  output logic [SIZE_W-1:0] idx
);
  logic busy;

  assign take = in_valid && busy && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (take) begin
      idx <= idx + 1'b1;
      if (finish) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/hdr_crc_units.sv
module hdr_crc8_unit
  import hdr_chk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= CRC8_INIT;
    else if (clear) crc <= CRC8_INIT;
    else if (en)    crc <= crc8_step(crc, din);
  end
endmodule

module hdr_crc32c_unit
  import hdr_chk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_nxt
);
  logic [31:0] state;

  assign crc_nxt = crc32c_step(state, din);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state <= CRC32_INIT;
    else if (clear) state <= CRC32_INIT;
    else if (en)    state <= crc_nxt;
  end
endmodule

// File: rtl/hdr_field_capture.sv
module hdr_field_capture
  import hdr_chk_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  take,
  input  logic [SIZE_W-1:0]     idx,
  input  logic [7:0]            din,
  output logic [7:0]            exp8,
  output logic [31:0]           exp32,
  output logic [8*ID_BYTES-1:0] uid_raw,
  output logic [7:0]            len_lo,
  output logic                  rev_hi
);
  logic [7:0] id_lane [ID_BYTES];
  logic [7:0] dc_lane [DCRC_BYTES];

  for (genvar g = 0; g < ID_BYTES; g++) begin : g_id
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     id_lane[g] <= '0;
      else if (clear) id_lane[g] <= '0;
      else if (take && idx == SIZE_W'(ID_FIRST + g)) id_lane[g] <= din;
    end
    assign uid_raw[8*g +: 8] = id_lane[g];
  end

  for (genvar g = 0; g < DCRC_BYTES; g++) begin : g_dc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dc_lane[g] <= '0;
      else if (clear) dc_lane[g] <= '0;
      else if (take && idx == SIZE_W'(DCRC_FIRST + g)) dc_lane[g] <= din;
    end
    assign exp32[8*g +: 8] = dc_lane[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp8   <= '0;
      len_lo <= '0;
      rev_hi <= 1'b0;
    end else if (clear) begin
      exp8   <= '0;
      len_lo <= '0;
      rev_hi <= 1'b0;
    end else if (take) begin
      if (idx == SIZE_W'(IDX_CRC8))   exp8   <= din;
      if (idx == SIZE_W'(LEN_LO_IDX)) len_lo <= din;
      if (idx == SIZE_W'(REV_IDX))    rev_hi <= (din > 8'd1);
    end
  end
endmodule

// File: rtl/hdr_integrity_chk.sv
module hdr_integrity_chk
  import hdr_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              done,
  output logic              pass,
  output logic              id_ok,
  output logic              data_ok,
  output logic              size_err,
  output logic              rev_warn,
  output logic [63:0]       uid,
  output logic [SIZE_W-1:0] image_size
);
  localparam int UID_W = 8 * ID_BYTES;

  // Named internal events
  logic                 take;
  logic                 finish;
  logic                 at_len_hi;
  logic                 short_img;
  logic [SIZE_W-1:0]    idx;
  logic [SIZE_W-1:0]    size_now;
  logic [LEN_BITS-1:0]  len_now;
  logic                 crc8_en;
  logic                 crc32_en;
  logic                 id_match;
  logic                 data_match;

  logic [7:0]           crc8_val;
  logic [31:0]          crc32_nxt;
  logic [7:0]           exp8;
  logic [31:0]          exp32;
  logic [UID_W-1:0]     uid_raw;
  logic [7:0]           len_lo;
  logic                 rev_hi;

  assign in_ready = 1'b1;

  hdr_byte_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .finish(finish), .take(take), .idx(idx)
  );

  hdr_field_capture u_cap (
    .clk(clk), .rst_n(rst_n), .clear(start), .take(take), .idx(idx),
    .din(in_data), .exp8(exp8), .exp32(exp32), .uid_raw(uid_raw),
    .len_lo(len_lo), .rev_hi(rev_hi)
  );

  assign crc8_en  = take && (idx >= SIZE_W'(ID_FIRST)) && (idx < SIZE_W'(DCRC_FIRST));
  assign crc32_en = take && (idx >= SIZE_W'(PAY_START));

  hdr_crc8_unit u_crc8 (
    .clk(clk), .rst_n(rst_n), .clear(start), .en(crc8_en),
    .din(in_data), .crc(crc8_val)
  );

  hdr_crc32c_unit u_crc32 (
    .clk(clk), .rst_n(rst_n), .clear(start), .en(crc32_en),
    .din(in_data), .crc_nxt(crc32_nxt)
  );

  assign len_now   = {in_data[LEN_BITS-9:0], len_lo};
  assign size_now  = SIZE_W'(len_now) + SIZE_W'(PAY_START);
  assign at_len_hi = take && (idx == SIZE_W'(LEN_HI_IDX));
  assign short_img = at_len_hi && (size_now < SIZE_W'(HDR_BYTES));
  assign finish    = short_img ||
                     (take && (idx > SIZE_W'(LEN_HI_IDX)) && (idx == image_size - 1'b1));
  assign id_match   = (crc8_val == exp8);
  assign data_match = !short_img && ((~crc32_nxt) == exp32);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      pass       <= 1'b0;
      id_ok      <= 1'b0;
      data_ok    <= 1'b0;
      size_err   <= 1'b0;
      rev_warn   <= 1'b0;
      uid        <= '0;
      image_size <= '0;
    end else if (start) begin
      done       <= 1'b0;
      pass       <= 1'b0;
      id_ok      <= 1'b0;
      data_ok    <= 1'b0;
      size_err   <= 1'b0;
      rev_warn   <= 1'b0;
      uid        <= '0;
      image_size <= '0;
    end else begin
      if (at_len_hi) image_size <= size_now;
      if (finish) begin
        done     <= 1'b1;
        id_ok    <= id_match;
        data_ok  <= data_match;
        size_err <= short_img;
        rev_warn <= rev_hi;
        uid      <= id_match ? uid_raw : '0;
        pass     <= id_match && data_match && !short_img;
      end
    end
  end
endmodule

// File: rtl/hdr_integrity_chk_sva.sv
module hdr_integrity_chk_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        in_ready,
  input logic        take,
  input logic        done,
  input logic        pass,
  input logic        id_ok,
  input logic        data_ok,
  input logic        size_err,
  input logic [63:0] uid
);
  assert_ready_high_R1: assert property (@(posedge clk) disable iff (!rst_n) in_ready);
  assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n) start |=> !done && !pass);
  assert_uid_gated_R3: assert property (@(posedge clk) disable iff (!rst_n) !id_ok |-> uid == 64'd0);
  assert_short_no_data_R6: assert property (@(posedge clk) disable iff (!rst_n) size_err |-> !data_ok && done);
  assert_pass_parts_R8: assert property (@(posedge clk) disable iff (!rst_n) pass |-> id_ok && data_ok && !size_err);
  assert_no_early_result_R9: assert property (@(posedge clk) disable iff (!rst_n) !done |-> !pass && !id_ok);
  assert_no_take_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n) done |-> !take);
  assert_hold_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(uid) && $stable(pass));
endmodule

bind hdr_integrity_chk hdr_integrity_chk_sva u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready), .take(take),
  .done(done), .pass(pass), .id_ok(id_ok), .data_ok(data_ok),
  .size_err(size_err), .uid(uid)
);

// File: tb/hdr_integrity_chk_bench.sv
module hdr_integrity_chk_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        in_ready, done, pass, id_ok, data_ok, size_err, rev_warn;
  logic [63:0] uid;
  logic [10:0] image_size;

  int checks = 0;
  int bad = 0;
  bit model_done = 1'b0;
  bit finished = 1'b0;

  byte unsigned img [0:1100];
  int img_size;
  logic [63:0] exp_uid;

  always #10 clk = ~clk;

  hdr_integrity_chk u_hdr_integrity_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .done(done), .pass(pass),
    .id_ok(id_ok), .data_ok(data_ok), .size_err(size_err),
    .rev_warn(rev_warn), .uid(uid), .image_size(image_size)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Per-clock comparison of completion and ready against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(done == model_done, "R9 done timing", 64'(done), 64'(model_done));
      chk(in_ready == 1'b1, "R1 ready", 64'(in_ready), 64'd1);
    end
  end

  function automatic byte unsigned ref_crc8(input int first, input int n);
    byte unsigned v = 8'hFF;
    for (int i = first; i < first + n; i++) begin
      v = v ^ img[i];
      for (int j = 0; j < 8; j++) v = v[7] ? byte'((v << 1) ^ 8'h07) : byte'(v << 1);
    end
    return v;
  endfunction

  function automatic int unsigned ref_crc32c(input int first, input int n);
    int unsigned r = 32'hFFFFFFFF;
    for (int i = first; i < first + n; i++) begin
      for (int b = 0; b < 8; b++) begin
        bit mix = r[0] ^ img[i][b];
        r = r >> 1;
        if (mix) r = r ^ 32'h82F63B78;
      end
    end
    return ~r;
  endfunction

  task automatic build(input int dlen, input int rev, input int hibits, input int seed);
    int unsigned c;
    img_size = dlen + 13;
    for (int i = 0; i < 1100; i++) img[i] = byte'((i * 37 + seed * 11 + 5) & 255);
    img[13] = byte'(rev);
    img[14] = byte'(dlen & 255);
    img[15] = byte'(((hibits & 63) << 2) | ((dlen >> 8) & 3));
    img[0] = ref_crc8(1, 8);
    c = ref_crc32c(13, (img_size > 13) ? img_size - 13 : 0);
    for (int k = 0; k < 4; k++) img[9 + k] = byte'((c >> (8 * k)) & 255);
    exp_uid = 64'd0;
    for (int k = 0; k < 8; k++) exp_uid[8*k +: 8] = img[1 + k];
  endtask

  task automatic do_start();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #2;
    start = 1'b0;
    model_done = 1'b0;
  endtask

  task automatic send(input byte unsigned b, input bit last);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(posedge clk);
    #2;
    in_valid = 1'b0;
    if (last) model_done = 1'b1;
  endtask

  task automatic run(input int n_send, input bit gaps);
    int fin = (img_size < 22) ? 15 : img_size - 1;
    do_start();
    for (int i = 0; i < n_send; i++) begin
      if (gaps && (i % 3 == 0)) begin
        @(negedge clk);
        @(negedge clk);
      end
      send(img[i], i == fin);
      if (i == 15) chk(image_size == 11'(img_size), "R5 size after byte 15", 64'(image_size), 64'(img_size));
    end
  endtask

  task automatic results(input string tag, input bit e_pass, input bit e_id, input bit e_data,
                         input bit e_short, input bit e_rev, input logic [63:0] e_uid);
    chk(done == 1'b1,      {tag, " R9 done"},     64'(done),     64'd1);
    chk(pass == e_pass,    {tag, " R8 pass"},     64'(pass),     64'(e_pass));
    chk(id_ok == e_id,     {tag, " R2 id_ok"},    64'(id_ok),    64'(e_id));
    chk(data_ok == e_data, {tag, " R4 data_ok"},  64'(data_ok),  64'(e_data));
    chk(size_err == e_short, {tag, " R6 size_err"}, 64'(size_err), 64'(e_short));
    chk(rev_warn == e_rev, {tag, " R7 rev_warn"}, 64'(rev_warn), 64'(e_rev));
    chk(uid == e_uid,      {tag, " R3 uid"},      uid,           e_uid);
    chk(image_size == 11'(img_size), {tag, " R5 image_size"}, 64'(image_size), 64'(img_size));
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    #5;
    // R1 reset state
    chk(done == 0 && pass == 0 && uid == 0 && image_size == 0, "R1 reset state", 64'(done), 64'd0);
    // R1 bytes before any start are ignored
    build(20, 1, 0, 1);
    for (int i = 0; i < 20; i++) send(img[i], 1'b0);
    chk(done == 0 && image_size == 0, "R1 bytes before start ignored", 64'(image_size), 64'd0);

    // Good image
    build(20, 1, 0, 2);
    run(img_size, 1'b0);
    results("good", 1, 1, 1, 0, 0, exp_uid);

    // R7 revision warning with idle gaps (R9 stall)
    build(40, 3, 0, 3);
    run(img_size, 1'b1);
    results("rev3 gaps", 1, 1, 1, 0, 1, exp_uid);

    // R2 corrupted identifier CRC
    build(30, 0, 0, 4);
    img[0] = img[0] ^ 8'h10;
    run(img_size, 1'b0);
    results("bad id", 0, 0, 1, 0, 0, 64'd0);

    // R4 corrupted payload
    build(25, 1, 0, 5);
    img[img_size - 1] = img[img_size - 1] ^ 8'h01;
    run(img_size, 1'b0);
    results("bad data", 0, 1, 0, 0, 0, exp_uid);

    // R5 upper bits of byte 15 ignored, larger length
    build(300, 1, 6'h2B, 6);
    run(img_size, 1'b0);
    results("hibits", 1, 1, 1, 0, 0, exp_uid);

    // R6 short image, then R10 trailing bytes ignored
    build(5, 1, 0, 7);
    run(22, 1'b0);
    results("short R10", 0, 1, 0, 1, 0, exp_uid);

    // R10 extra bytes after a good image
    build(9, 2, 0, 8);
    run(img_size + 12, 1'b0);
    results("trail R10", 1, 1, 1, 0, 1, exp_uid);

    // R1 start clears results
    do_start();
    chk(done == 0 && pass == 0 && uid == 0 && image_size == 0 && rev_warn == 0,
        "R1 start clears", 64'(done), 64'd0);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule